// File: doc/BRIEF.md
# Conditional Branch Decoder and Target Calculator

This block looks at one 32-bit instruction word together with the address it was fetched from. It decides whether the word is one of six conditional branches. Two of them compare two registers: equal and not-equal. Four of them test one register against zero: less-or-equal, greater-than, less-than, and greater-or-equal. For a branch, the block names which kind it is. It always exposes the two register index fields. It flags whether the second index is a real operand. It also computes the absolute branch destination.

The unit is purely combinational. A fetch or predecode stage can place it beside the instruction path. The branch kind and destination are then available in the same cycle the word arrives. The branch condition is not evaluated here, and the program counter is not updated here.

Top module: `bdec_branch_unit`

## Requirements
- R1: Primary opcode (bits 31:26) 4 gives branch kind code 1 (equal) with `is_branch_o`=1 and `rt_used_o`=1, whatever the rt field holds.
- R2: Primary opcode 5 gives kind code 2 (not-equal) with `is_branch_o`=1 and `rt_used_o`=1, whatever the rt field holds.
- R3: Opcode 6 with rt field (bits 20:16) equal to 0 gives kind 3 (less-or-equal-zero). Opcode 7 with rt equal to 0 gives kind 4 (greater-than-zero). Both set `rt_used_o`=0. With any nonzero rt, these opcodes are not branches.
- R4: Opcode 1 with rt equal to 0 gives kind 5 (less-than-zero). Opcode 1 with rt equal to 1 gives kind 6 (greater-or-equal-zero). Both set `rt_used_o`=0. Opcode 1 with any other rt value is not a branch.
- R5: A word that is not a branch gives `is_branch_o`=0, `kind_o`=0 and `rt_used_o`=0. `is_branch_o` is 1 exactly when `kind_o` is nonzero.
- R6: `rs_o` always equals bits 25:21 of the word, and `rt_o` always equals bits 20:16.
- R7: `target_o` = `pc_i` + 4 + (bits 15:0 sign-extended to 32 bits, then shifted left by 2), taken modulo 2^32. For example, word 0x12120004 at address 0x00400014 decodes as the equal kind with rs=16, rt=18 and target 0x00400028.
- R8: A negative offset moves the target backwards from `pc_i`+4. For example, offset 0xFFFB gives (`pc_i`+4)−20. Sums past either end of the 32-bit address space wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word to decode |
| pc_i | input | 32 | Byte address of that instruction |
| is_branch_o | output | 1 | Word is one of the six conditional branches |
| kind_o | output | 3 | Branch kind code: 0 none, 1 eq, 2 ne, 3 lez, 4 gtz, 5 ltz, 6 gez |
| rs_o | output | 5 | First register index field |
| rt_o | output | 5 | Second register index field |
| rt_used_o | output | 1 | Second register index is a real operand |
| target_o | output | 32 | Absolute branch destination |

## Verification
Two situations are hard to reach with uniformly random words. The first is the narrow band of near-miss encodings: single-register opcodes with a nonzero rt, and the register-immediate group with rt values other than 0 and 1. The second is address wraparound. Random stimulus is therefore biased toward opcodes 0 to 7 and toward rt values 0 to 2. Directed words cover each near-miss, the most negative and most positive offsets, and addresses at the top and bottom of the address space.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
  localparam int XLEN     = 32;
  localparam int REG_W    = 5;
  localparam int OPC_W    = 6;
  localparam int OFF_W    = 16;
  localparam int ALIGN_SH = 2;
  localparam int OPC_LSB  = 26;
  localparam int RS_LSB   = 21;
  localparam int RT_LSB   = 16;
  localparam int KIND_W   = 3;
  localparam int N_RULES  = 6;

  localparam logic [KIND_W-1:0] BK_NONE = 3'd0;
  localparam logic [KIND_W-1:0] BK_EQ   = 3'd1;
  localparam logic [KIND_W-1:0] BK_NE   = 3'd2;
  localparam logic [KIND_W-1:0] BK_LEZ  = 3'd3;
  localparam logic [KIND_W-1:0] BK_GTZ  = 3'd4;
  localparam logic [KIND_W-1:0] BK_LTZ  = 3'd5;
  localparam logic [KIND_W-1:0] BK_GEZ  = 3'd6;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic              rt_fixed;  // rt field must equal rt_val
    logic [REG_W-1:0]  rt_val;
    logic [KIND_W-1:0] kind;
    logic              rt_used;
  } br_rule_t;

  localparam br_rule_t RULES [N_RULES] = '{
    '{opc: 6'd4, rt_fixed: 1'b0, rt_val: 5'd0, kind: BK_EQ,  rt_used: 1'b1},
    '{opc: 6'd5, rt_fixed: 1'b0, rt_val: 5'd0, kind: BK_NE,  rt_used: 1'b1},
    '{opc: 6'd6, rt_fixed: 1'b1, rt_val: 5'd0, kind: BK_LEZ, rt_used: 1'b0},
    '{opc: 6'd7, rt_fixed: 1'b1, rt_val: 5'd0, kind: BK_GTZ, rt_used: 1'b0},
    '{opc: 6'd1, rt_fixed: 1'b1, rt_val: 5'd0, kind: BK_LTZ, rt_used: 1'b0},
    '{opc: 6'd1, rt_fixed: 1'b1, rt_val: 5'd1, kind: BK_GEZ, rt_used: 1'b0}
  };
endpackage

// File: rtl/bdec_field_split.sv
module bdec_field_split
  import bdec_pkg::*;
(
  input  logic [XLEN-1:0]  insn_i,
  output logic [OPC_W-1:0] opc_o,
  output logic [REG_W-1:0] rs_o,
  output logic [REG_W-1:0] rt_o,
  output logic [OFF_W-1:0] off_o
);
  assign opc_o = insn_i[OPC_LSB +: OPC_W];
  assign rs_o  = insn_i[RS_LSB  +: REG_W];
  assign rt_o  = insn_i[RT_LSB  +: REG_W];
  assign off_o = insn_i[0       +: OFF_W];
endmodule

// File: rtl/bdec_classify.sv
module bdec_classify
  import bdec_pkg::*;
(
  input  logic [OPC_W-1:0]  opc_i,
  input  logic [REG_W-1:0]  rt_i,
  output logic              hit_o,
  output logic [KIND_W-1:0] kind_o,
  output logic              rt_used_o
);
  logic [N_RULES-1:0] match;

  for (genvar g = 0; g < N_RULES; g++) begin : g_rule
    assign match[g] = (opc_i == RULES[g].opc) &&
                      (!RULES[g].rt_fixed || (rt_i == RULES[g].rt_val));
  end

  assign hit_o = |match;

  // rules are disjoint, so OR-merging the selected entries is exact
  always_comb begin
    kind_o    = BK_NONE;
    rt_used_o = 1'b0;
    for (int i = 0; i < N_RULES; i++) begin
      if (match[i]) begin
        kind_o    = kind_o | RULES[i].kind;
        rt_used_o = rt_used_o | RULES[i].rt_used;
      end
    end
  end

  always_comb begin
    a_r5_rules_exclusive: assert ($onehot0(match))
      else $error("R5: more than one branch rule matched");
  end
endmodule

// File: rtl/bdec_target_gen.sv
module bdec_target_gen
  import bdec_pkg::*;
#(
  parameter int AW  = XLEN,
  parameter int OW  = OFF_W,
  parameter int SH  = ALIGN_SH
) (
  input  logic [AW-1:0] pc_i,
  input  logic [OW-1:0] off_i,
  output logic [AW-1:0] target_o
);
  localparam int EXT_W = AW - OW - SH;
  localparam logic [AW-1:0] STEP = AW'(1) << SH;

  logic [AW-1:0] byte_off;
  logic [AW-1:0] seq_pc;

  assign byte_off = {{EXT_W{off_i[OW-1]}}, off_i, {SH{1'b0}}};
  assign seq_pc   = pc_i + STEP;
  assign target_o = seq_pc + byte_off;

  logic [AW-1:0] span;
  assign span = target_o - pc_i - STEP;

  always_comb begin
    a_r7_align_kept: assert (target_o[SH-1:0] == pc_i[SH-1:0])
      else $error("R7: target alignment differs from pc");
    a_r8_sign_span: assert (off_i[OW-1] ? (&span[AW-1:OW+SH-1])
                                        : (~|span[AW-1:OW+SH-1]))
      else $error("R8: target displacement has wrong direction");
  end
endmodule

// File: rtl/bdec_branch_unit.sv
module bdec_branch_unit
  import bdec_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic [31:0] pc_i,
  output logic        is_branch_o,
  output logic [2:0]  kind_o,
  output logic [4:0]  rs_o,
  output logic [4:0]  rt_o,
  output logic        rt_used_o,
  output logic [31:0] target_o
);
  logic [OPC_W-1:0] opc;
  logic [OFF_W-1:0] off;

  bdec_field_split u_split (
    .insn_i (insn_i),
    .opc_o  (opc),
    .rs_o   (rs_o),
    .rt_o   (rt_o),
    .off_o  (off)
  );

  bdec_classify u_class (
    .opc_i     (opc),
    .rt_i      (rt_o),
    .hit_o     (is_branch_o),
    .kind_o    (kind_o),
    .rt_used_o (rt_used_o)
  );

  bdec_target_gen u_tgt (
    .pc_i     (pc_i),
    .off_i    (off),
    .target_o (target_o)
  );

  always_comb begin
    a_r5_flag_matches_kind: assert (is_branch_o == (kind_o != BK_NONE))
      else $error("R5: branch flag disagrees with kind");
    a_r1_two_reg_uses_rt: assert (!(kind_o == BK_EQ || kind_o == BK_NE) || rt_used_o)
      else $error("R1: two-register branch without rt operand");
    a_r3_single_reg_no_rt: assert (!(kind_o >= BK_LEZ) || !rt_used_o)
      else $error("R3: single-register branch claims rt operand");
    a_r4_regimm_opcode: assert (!(kind_o == BK_LTZ || kind_o == BK_GEZ) || opc == 6'd1)
      else $error("R4: regimm kind from wrong opcode");
  end
endmodule

// File: tb/bdec_branch_unit_tb_top.sv
module bdec_branch_unit_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] insn, pc, target;
  logic        is_br, rt_used;
  logic [2:0]  kind;
  logic [4:0]  rs, rt;

  bdec_branch_unit dut_i (
    .insn_i (insn), .pc_i (pc), .is_branch_o (is_br), .kind_o (kind),
    .rs_o (rs), .rt_o (rt), .rt_used_o (rt_used), .target_o (target)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic logic [2:0] m_kind(logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [4:0] t  = w[20:16];
    case (op)
      6'd4: return 3'd1;
      6'd5: return 3'd2;
      6'd6: return (t == 0) ? 3'd3 : 3'd0;
      6'd7: return (t == 0) ? 3'd4 : 3'd0;
      6'd1: return (t == 0) ? 3'd5 : ((t == 1) ? 3'd6 : 3'd0);
      default: return 3'd0;
    endcase
  endfunction

  function automatic string k_tag(logic [2:0] k, logic [31:0] w);
    case (k)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3, 3'd4: return "R3";
      3'd5, 3'd6: return "R4";
      default: return (w[31:26] == 6'd1) ? "R4" :
                      ((w[31:26] == 6'd6 || w[31:26] == 6'd7) ? "R3" : "R5");
    endcase
  endfunction

  function automatic logic [31:0] m_target(logic [31:0] w, logic [31:0] a);
    int o;
    o = $signed(w[15:0]);
    return a + 32'd4 + 32'(o * 4);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, logic [31:0] a, string ttag);
    logic [2:0] ek;
    string kt;
    @(negedge clk);
    insn = w;
    pc   = a;
    #3;
    ek = m_kind(w);
    kt = k_tag(ek, w);
    chk(kt, "kind", 32'(kind), 32'(ek));
    chk((ek == 0) ? "R5" : kt, "is_branch", 32'(is_br), 32'(ek != 0));
    chk(kt, "rt_used", 32'(rt_used), 32'(ek == 3'd1 || ek == 3'd2));
    chk("R6", "rs", 32'(rs), 32'(w[25:21]));
    chk("R6", "rt", 32'(rt), 32'(w[20:16]));
    chk(ttag, "target", target, m_target(w, a));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, a;
    void'($urandom(32'd20240611));
    insn = 32'h0;
    pc   = 32'h0;
    repeat (2) @(posedge clk);
    #3;
    // reset-time state: zero word is not a branch
    chk("R5", "reset is_branch", 32'(is_br), 32'd0);
    chk("R5", "reset kind", 32'(kind), 32'd0);
    rst_ni = 1'b1;

    // R7 worked example
    apply(32'h12120004, 32'h00400014, "R7");
    chk("R7", "example target", target, 32'h00400028);
    chk("R1", "example rs", 32'(rs), 32'd16);
    chk("R1", "example rt", 32'(rt), 32'd18);
    apply(32'h14A3FFFF, 32'h00001000, "R8");                 // R2 ne, back one word
    apply({6'd6, 5'd9, 5'd0, 16'h0010}, 32'h00400000, "R7"); // R3 lez
    apply({6'd6, 5'd9, 5'd3, 16'h0010}, 32'h00400000, "R7"); // R3 near-miss
    apply({6'd7, 5'd2, 5'd0, 16'h0001}, 32'h00400100, "R7"); // R3 gtz
    apply({6'd7, 5'd2, 5'd31, 16'h0001}, 32'h00400100, "R7");// R3 near-miss
    apply({6'd1, 5'd4, 5'd0, 16'h0002}, 32'h00400200, "R7"); // R4 ltz
    apply({6'd1, 5'd4, 5'd1, 16'h0002}, 32'h00400200, "R7"); // R4 gez
    apply({6'd1, 5'd4, 5'd2, 16'h0002}, 32'h00400200, "R7"); // R4 near-miss
    apply({6'd1, 5'd4, 5'd17, 16'h0002}, 32'h00400200, "R7");// R4 near-miss
    apply(32'h02118020, 32'h0040001C, "R7");                 // R5 opcode 0
    apply(32'h8E080000, 32'h00400018, "R7");                 // R5 load word
    // R8 negative offset 0xFFFB: five words before pc+4
    apply({6'd4, 5'd8, 5'd0, 16'hFFFB}, 32'h00400010, "R8");
    chk("R8", "minus five words", target, 32'h00400000);
    apply({6'd5, 5'd1, 5'd2, 16'h8000}, 32'h00000000, "R8");
    chk("R8", "most negative wraps", target, 32'hFFFE0004);
    apply({6'd4, 5'd1, 5'd2, 16'h0001}, 32'hFFFFFFF8, "R8");
    chk("R8", "top wraps to zero", target, 32'h00000000);
    apply({6'd4, 5'd1, 5'd2, 16'h7FFF}, 32'hFFFF0000, "R8");

    for (int i = 0; i < 3000; i++) begin
      w = $urandom;
      a = {$urandom, 2'b00};
      if (($urandom % 4) != 0) w[31:26] = 6'($urandom % 8);
      if (($urandom % 2) != 0) w[20:16] = 5'($urandom % 3);
      apply(w, a, w[15] ? "R8" : "R7");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule